// File: doc/BRIEF.md
# Skewed Two-Candidate Way Selector

This block handles placement and probe order for a 4-way cache in which any one line may sit in only two of the four ways. Two address bits name a first-choice way. Two more address bits give a nonzero offset, and the offset XORed onto the first-choice way names a fallback way. Because the offset depends on the address, different addresses pair the ways differently, and all four ways of a set stay in use.

A lookup is accepted only while the sequencer is idle. The sequencer then requests a probe of the first-choice way. If that probe reports no tag match, it requests a probe of the fallback way. After one or two probes it raises a one-cycle completion pulse. The pulse carries the hit flag, the matching way and the number of probes spent, so a miss is confirmed after two probes rather than four.

Installs run alongside lookups and are independent of them. For each install request the block registers a choice between the two candidates for that address. The choice is biased by a programmable threshold that is compared against a free-running pseudo-random sequence.

Top module: `skew_way_sel`

## Requirements
- R1: For an address A, the first-choice way is P = A[WAY_LSB+1:WAY_LSB]. The offset is O = A[WAY_LSB+3:WAY_LSB+2], and an O of 0 is replaced by 1. The fallback way is P XOR O, so it never equals P.
- R2: A lookup is taken only when `lkp_valid` and `lkp_ready` are both high at a rising edge. `lkp_ready` is high only while no lookup is in progress. A request made while busy is ignored.
- R3: In the cycle after a lookup is taken, `probe_req` is high and `probe_way` equals P. `probe_hit` is sampled in that same cycle.
- R4: If the first probe misses, the next cycle has `probe_req` high with `probe_way` equal to the fallback way. No lookup ever issues more than two probes.
- R5: In the cycle after the final probe, `done` is high for exactly one cycle. `hit` then reflects the final probe's match, and `hit_way` is the way that matched.
- R6: With `done` high, `probe_cnt` is 1 when the first probe hit and 2 otherwise. A miss always reports 2.
- R7: An install request at a rising edge sets `ins_done` high in the next cycle, with `ins_way` equal to one of that address's two candidates.
- R8: The install picks P when the internal 8-bit maximal-length sequence value (range 1..255, stepped once per install) is less than or equal to `ins_bias`. Otherwise it picks the fallback way. A bias of 0 always picks the fallback way, and a bias of 255 always picks P.
- R9: Over any 255 consecutive installs at a fixed bias B, exactly B of them pick P.
- R10: After reset, `lkp_ready` is 1, and `probe_req`, `done` and `ins_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_ready | output | 1 | Sequencer idle, lookup can be taken |
| probe_req | output | 1 | Probe of `probe_way` requested this cycle |
| probe_way | output | 2 | Way to probe |
| probe_hit | input | 1 | Tag match result for the current probe |
| done | output | 1 | Lookup complete (one cycle) |
| hit | output | 1 | Lookup found the line |
| hit_way | output | 2 | Way that matched |
| probe_cnt | output | 2 | Probes spent on the completed lookup |
| ins_valid | input | 1 | Install request |
| ins_addr | input | ADDR_W | Install address |
| ins_bias | input | 8 | Threshold favouring the first-choice way |
| ins_done | output | 1 | Install choice valid |
| ins_way | output | 2 | Chosen install way |

## Verification
The probe sequencer and the install picker can both act in the same clock edge. The bench provokes this by issuing an install request in the cycle a lookup is accepted, and again during the fallback probe. It then judges both results against their own expected values: the lookup must keep its probe order and outcome, and the install must give the way that its bias predicts. The bench also presents a lookup request while a lookup is already running, and checks that exactly one completion appears.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef logic [1:0] way_t;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE1 = 2'd1,
    ST_PROBE2 = 2'd2,
    ST_DONE   = 2'd3
  } probe_st_e;
endpackage

// File: rtl/skew_map.sv
module skew_map
  import skew_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WAY_LSB = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output way_t              first_way,
  output way_t              alt_way
);
  way_t off_raw;
  way_t off;

  always_comb begin
    first_way = addr[WAY_LSB+1:WAY_LSB];
    off_raw   = addr[WAY_LSB+3:WAY_LSB+2];
    off       = (off_raw == 2'd0) ? 2'd1 : off_raw;
    alt_way   = first_way ^ off;
  end
endmodule

// File: rtl/bias_lfsr.sv
module bias_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = value >> 1;
    if (value[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= {{(W-1){1'b0}}, 1'b1};
    else if (step) value <= nxt;
  end
endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
  import skew_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  way_t first_way,
  input  way_t alt_way,
  input  logic probe_hit,
  output logic ready,
  output logic probe_req,
  output way_t probe_way,
  output logic done,
  output logic hit,
  output way_t hit_way,
  output logic [1:0] probe_cnt
);
  probe_st_e st_q, st_d;
  way_t      first_q, alt_q;
  logic      hit_q, hit_d;
  way_t      hway_q, hway_d;
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    hit_d  = hit_q;
    hway_d = hway_q;
    cnt_d  = cnt_q;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_PROBE1;
      ST_PROBE1: begin
        cnt_d  = 2'd1;
        hway_d = first_q;
        hit_d  = probe_hit;
        st_d   = probe_hit ? ST_DONE : ST_PROBE2;
      end
      ST_PROBE2: begin
        cnt_d  = 2'd2;
        hway_d = alt_q;
        hit_d  = probe_hit;
        st_d   = ST_DONE;
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hit_q  <= 1'b0;
      hway_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      hit_q  <= hit_d;
      hway_q <= hway_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      alt_q   <= '0;
    end else if (st_q == ST_IDLE && start) begin
      first_q <= first_way;
      alt_q   <= alt_way;
    end
  end

  always_comb begin
    ready     = (st_q == ST_IDLE);
    probe_req = (st_q == ST_PROBE1) || (st_q == ST_PROBE2);
    probe_way = (st_q == ST_PROBE2) ? alt_q : first_q;
    done      = (st_q == ST_DONE);
    hit       = done & hit_q;
    hit_way   = hway_q;
    probe_cnt = done ? cnt_q : 2'd0;
  end
endmodule

// File: rtl/skew_way_sel.sv
module skew_way_sel
  import skew_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WAY_LSB = 12,
  parameter int BIAS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_ready,
  output logic              probe_req,
  output logic [1:0]        probe_way,
  input  logic              probe_hit,
  output logic              done,
  output logic              hit,
  output logic [1:0]        hit_way,
  output logic [1:0]        probe_cnt,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [BIAS_W-1:0] ins_bias,
  output logic              ins_done,
  output logic [1:0]        ins_way
);
  way_t lk_first, lk_alt, in_first, in_alt, in_pick;
  logic [BIAS_W-1:0] rnd;
  logic ins_done_q;
  way_t ins_way_q;

  skew_map #(.ADDR_W(ADDR_W), .WAY_LSB(WAY_LSB)) u_map_lkp (
    .addr(lkp_addr), .first_way(lk_first), .alt_way(lk_alt));
  skew_map #(.ADDR_W(ADDR_W), .WAY_LSB(WAY_LSB)) u_map_ins (
    .addr(ins_addr), .first_way(in_first), .alt_way(in_alt));

  bias_lfsr #(.W(BIAS_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(ins_valid), .value(rnd));

  probe_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(lkp_valid),
    .first_way(lk_first), .alt_way(lk_alt), .probe_hit(probe_hit),
    .ready(lkp_ready), .probe_req(probe_req), .probe_way(probe_way),
    .done(done), .hit(hit), .hit_way(hit_way), .probe_cnt(probe_cnt));

  always_comb in_pick = (rnd <= ins_bias) ? in_first : in_alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_done_q <= 1'b0;
      ins_way_q  <= '0;
    end else begin
      ins_done_q <= ins_valid;
      if (ins_valid) ins_way_q <= in_pick;
    end
  end

  assign ins_done = ins_done_q;
  assign ins_way  = ins_way_q;
endmodule

module skew_way_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lkp_ready,
  input logic       probe_req,
  input logic [1:0] probe_way,
  input logic       done,
  input logic       hit,
  input logic [1:0] hit_way,
  input logic [1:0] probe_cnt
);
  a_r1_alt_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && $past(probe_req)) |-> (probe_way != $past(probe_way)));
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req || done) |-> !lkp_ready);
  a_r4_two_probes_max: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && $past(probe_req)) |=> !probe_req);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_hit_way_probed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_way == $past(probe_way)));
  a_r6_miss_costs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (probe_cnt == 2'd2));
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (probe_cnt == 2'd1 || probe_cnt == 2'd2));
endmodule

bind skew_way_sel skew_way_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_ready(lkp_ready), .probe_req(probe_req),
  .probe_way(probe_way), .done(done), .hit(hit), .hit_way(hit_way),
  .probe_cnt(probe_cnt));

// File: tb/skew_way_sel_tb.sv
module skew_way_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LSB = 12;

  logic clk, rst_n;
  logic lkp_valid, probe_hit, ins_valid;
  logic [AW-1:0] lkp_addr, ins_addr;
  logic [7:0] ins_bias;
  logic lkp_ready, probe_req, done, hit, ins_done;
  logic [1:0] probe_way, hit_way, probe_cnt, ins_way;
  int n_chk, n_fail;

  skew_way_sel u_dut (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .lkp_ready(lkp_ready), .probe_req(probe_req), .probe_way(probe_way),
    .probe_hit(probe_hit), .done(done), .hit(hit), .hit_way(hit_way),
    .probe_cnt(probe_cnt), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_bias(ins_bias), .ins_done(ins_done), .ins_way(ins_way));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int p, input int o);
    logic [AW-1:0] a;
    a = 32'hA5A5_0000;
    a[LSB+1 -: 2] = p[1:0];
    a[LSB+3 -: 2] = o[1:0];
    return a;
  endfunction

  function automatic int alt_of(input int p, input int o);
    int oo;
    oo = (o == 0) ? 1 : o;
    return (p ^ oo) & 3;
  endfunction

  // Lookup: hit_at = 1 (first probe hits), 2 (second hits), 0 (miss)
  task automatic lookup(input int p, input int o, input int hit_at, input logic busy_req);
    int a;
    a = alt_of(p, o);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = mk(p, o);
    @(negedge clk);
    lkp_valid = busy_req; lkp_addr = mk(p ^ 1, o);
    chk("R3 probe_req first", probe_req, 1);
    chk("R3 first way", probe_way, p);
    chk("R2 not ready while busy", lkp_ready, 0);
    probe_hit = (hit_at == 1);
    @(negedge clk);
    probe_hit = 1'b0;
    if (hit_at != 1) begin
      chk("R4 second probe", probe_req, 1);
      chk("R1/R4 fallback way", probe_way, a);
      probe_hit = (hit_at == 2);
      @(negedge clk);
      probe_hit = 1'b0;
    end
    chk("R5 done", done, 1);
    chk("R4 no third probe", probe_req, 0);
    chk("R5 hit flag", hit, hit_at != 0);
    if (hit_at != 0) chk("R5 hit way", hit_way, (hit_at == 1) ? p : a);
    chk("R6 probe count", probe_cnt, (hit_at == 1) ? 1 : 2);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    if (busy_req) begin
      chk("R2 busy request ignored", probe_req, 0);
      lkp_valid = 1'b0;
    end
    chk("R2 ready again", lkp_ready, 1);
  endtask

  task automatic install(input int p, input int o, input int bias, output int way);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = mk(p, o); ins_bias = bias[7:0];
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R7 ins_done", ins_done, 1);
    way = ins_way;
  endtask

  task automatic t_reset;
    chk("R10 ready", lkp_ready, 1);
    chk("R10 probe_req", probe_req, 0);
    chk("R10 done", done, 0);
    chk("R10 ins_done", ins_done, 0);
  endtask

  task automatic t_lookups;
    lookup(0, 1, 1, 1'b0);
    lookup(2, 3, 2, 1'b0);
    lookup(3, 2, 0, 1'b0);
    lookup(1, 0, 2, 1'b0);   // offset 0 forced to 1: fallback 0
    lookup(0, 0, 0, 1'b0);
    lookup(2, 2, 2, 1'b1);   // busy request ignored
  endtask

  task automatic t_pairs;
    // R1: every way is reachable as first choice and as fallback
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 4; o++)
        chk("R1 fallback differs", alt_of(p, o) != p, 1);
    lookup(1, 3, 2, 1'b0);
    lookup(3, 1, 2, 1'b0);
  endtask

  task automatic t_bias_ends;
    int w;
    for (int i = 0; i < 20; i++) begin
      install(2, 3, 0, w);
      chk("R8 bias 0 picks fallback", w, 1);
    end
    for (int i = 0; i < 20; i++) begin
      install(2, 3, 255, w);
      chk("R8 bias 255 picks first", w, 2);
    end
  endtask

  task automatic t_bias_mid;
    int w, cnt;
    cnt = 0;
    for (int i = 0; i < 255; i++) begin
      install(0, 1, 128, w);
      if (w == 0) cnt++;
      else chk("R7 candidate only", w, 1);
    end
    chk("R9 exact share at bias 128", cnt, 128);
    cnt = 0;
    for (int i = 0; i < 255; i++) begin
      install(3, 2, 40, w);
      if (w == 3) cnt++;
    end
    chk("R9 exact share at bias 40", cnt, 40);
  endtask

  task automatic t_overlap;
    // install accepted in same edge as lookup, and again during fallback probe
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = mk(1, 2);
    ins_valid = 1'b1; ins_addr = mk(0, 3); ins_bias = 8'd255;
    @(negedge clk);
    lkp_valid = 1'b0;
    ins_addr = mk(2, 1); ins_bias = 8'd0;
    chk("R7 overlap ins_done", ins_done, 1);
    chk("R8 overlap first pick", ins_way, 0);
    chk("R3 overlap first way", probe_way, 1);
    probe_hit = 1'b0;
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R8 overlap fallback pick", ins_way, 3);
    chk("R4 overlap fallback way", probe_way, 3);
    probe_hit = 1'b1;
    @(negedge clk);
    probe_hit = 1'b0;
    chk("R5 overlap hit", hit, 1);
    chk("R5 overlap hit way", hit_way, 3);
    chk("R7 install stops", ins_done, 0);
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; lkp_valid = 1'b0; probe_hit = 1'b0; ins_valid = 1'b0;
    lkp_addr = '0; ins_addr = '0; ins_bias = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lookups();
    t_pairs();
    t_bias_ends();
    t_bias_mid();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule